// File: doc/BRIEF.md
# FIFO Byte Bridge with Host-Granted Transmit Credit

This block models a parallel byte-wide bridge between a CPU and an outside world, in the style of a USB FIFO interface chip. The CPU sees an 8-bit data bus and two active-low strobes, one for reading and one for writing. It also sees two active-low status flags. One flag says received data is waiting. The other says the bridge will take a byte for transmission.

A host-side port plays the outside world. It pushes bytes into a receive queue that the CPU drains one byte per read strobe, oldest first. It grants the CPU permission to send a given number of bytes. It also collects every accepted byte as a one-cycle valid pulse.

Both sides share one clock. Strobes act on their falling edge, once per strobe. A read and a write strobe that are low at the same time are a protocol violation: the block records it in a sticky flag and lets the write win.

Top module: `fifo_byte_bridge`

## Requirements
- R1: After reset, cpu_rxf_n and cpu_txe_n are 1, cpu_rdata_oe is 0, cpu_rdata is 0, host_tx_valid is 0, and proto_err and host_overflow are 0.
- R2: A cycle with host_push high stores host_push_data in the receive queue. From the next cycle, cpu_rxf_n is 0 while at least one byte is queued.
- R3: A falling edge of cpu_rd_n removes the oldest queued byte. From the next cycle until cpu_rd_n rises, cpu_rdata_oe is 1 and cpu_rdata carries that byte. Bytes leave in the order they were pushed.
- R4: cpu_rxf_n returns to 1 after the read that removes the last byte. A read strobe on an empty queue leaves cpu_rdata_oe at 0 and cpu_rdata at 0.
- R5: While cpu_rd_n is 1, cpu_rdata_oe is 0 and cpu_rdata is 0.
- R6: A cycle with host_grant high replaces the transmit credit with host_grant_count. A grant does not add to the old credit. cpu_txe_n is 0 exactly while the credit is non-zero.
- R7: A falling edge of cpu_wr_n with non-zero credit has two effects. In the next cycle only, host_tx_valid is 1 and host_tx_data holds cpu_wdata. The credit also drops by one, so cpu_txe_n goes to 1 after the N-th write of an N-byte grant.
- R8: A falling edge of cpu_wr_n with zero credit is ignored: host_tx_valid stays 0.
- R9: A strobe held low for several cycles acts once. It gives one pop or one transmit pulse.
- R10: Any cycle with cpu_rd_n and cpu_wr_n both 0 sets proto_err, which stays 1 until reset. A read falling edge while cpu_wr_n is 0 is ignored and leaves the queue unchanged. The write is still accepted.
- R11: The queue holds RX_DEPTH bytes (16 by default). A push into a full queue is dropped and sets host_overflow, which stays 1 until reset. The queued bytes are unchanged.
- R12: If a grant and a write falling edge fall in the same cycle, the write is counted against the new grant. The remaining credit is host_grant_count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_wdata | input | 8 | Byte the CPU writes |
| cpu_rdata | output | 8 | Byte returned to the CPU, zero when not enabled |
| cpu_rdata_oe | output | 1 | Read data bus enable |
| cpu_rxf_n | output | 1 | Received data waiting, active low |
| cpu_txe_n | output | 1 | Transmit credit available, active low |
| host_push | input | 1 | Host pushes a byte into the receive queue |
| host_push_data | input | 8 | Byte pushed by the host |
| host_grant | input | 1 | Host loads a new transmit credit |
| host_grant_count | input | CREDIT_W | Number of bytes granted |
| host_tx_valid | output | 1 | One-cycle pulse for each accepted CPU byte |
| host_tx_data | output | 8 | Byte accepted from the CPU |
| host_overflow | output | 1 | Sticky: a push into a full queue was dropped |
| proto_err | output | 1 | Sticky: read and write strobes were low together |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- each strobe detector fires at most once per low period;
- a write with credit steps the credit down by exactly one;
- a write without credit never raises the valid pulse;
- a full queue ignores a push, and an empty queue ignores a pop;
- both error flags stay set once set.

Other behaviour can only be shown by the bench's scenarios:
- the byte order across a full queue;
- the exact cycle in which the data bus is enabled;
- a grant that replaces a credit rather than adding to it;
- a write that lands in the same cycle as a grant;
- which strobe wins in a collision.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/fbb_strobe_edge.sv
module fbb_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{prev: 1'b1};
        else        s_q <= s_d;
    end

    assign fall = s_q.prev & ~strobe_n;

    // R9: a held strobe cannot fire on two consecutive cycles
    assert_single_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/fbb_rx_fifo.sv
module fbb_rx_fifo
    import fbb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  byte_t push_data,
    input  logic  pop,
    output byte_t head,
    output logic  empty,
    output logic  full,
    output logic  dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             count;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            s_d.mem[s_q.wr_ptr] = push_data;
            s_d.wr_ptr = (s_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd_ptr = (s_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head    = s_q.mem[s_q.rd_ptr];
    assign empty   = (s_q.count == '0);
    assign full    = (s_q.count == CNT_W'(DEPTH));
    assign dropped = push && full;

    // R11: a push into a full queue leaves the occupancy unchanged
    assert_drop_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (s_q.count == $past(s_q.count)));
    // R4: a pop from an empty queue leaves it empty
    assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/fbb_tx_credit.sv
module fbb_tx_credit
    import fbb_pkg::*;
#(
    parameter int CREDIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grant,
    input  logic [CREDIT_W-1:0] grant_count,
    input  logic                wr_fire,
    input  byte_t               wdata,
    output logic                has_credit,
    output logic                tx_valid,
    output byte_t               tx_data
);
    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
        logic                valid;
        byte_t               data;
    } credit_state_t;

    credit_state_t s_d, s_q;
    logic [CREDIT_W-1:0] base;
    logic                take;

    always_comb begin
        s_d      = s_q;
        base     = grant ? grant_count : s_q.credit;
        take     = wr_fire && (base != '0);
        s_d.credit = take ? base - 1'b1 : base;
        s_d.valid  = take;
        if (take) s_d.data = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign has_credit = (s_q.credit != '0);
    assign tx_valid   = s_q.valid;
    assign tx_data    = s_q.data;

    // R7: an accepted write consumes exactly one unit of credit
    assert_credit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !grant && has_credit) |=> (s_q.credit == $past(s_q.credit) - 1'b1));
    // R8: a write without credit produces no transmit pulse
    assert_no_credit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !grant && !has_credit) |=> !tx_valid);
endmodule

// File: rtl/fifo_byte_bridge.sv
module fifo_byte_bridge
    import fbb_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int CREDIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_rd_n,
    input  logic                cpu_wr_n,
    input  logic [7:0]          cpu_wdata,
    output logic [7:0]          cpu_rdata,
    output logic                cpu_rdata_oe,
    output logic                cpu_rxf_n,
    output logic                cpu_txe_n,
    input  logic                host_push,
    input  logic [7:0]          host_push_data,
    input  logic                host_grant,
    input  logic [CREDIT_W-1:0] host_grant_count,
    output logic                host_tx_valid,
    output logic [7:0]          host_tx_data,
    output logic                host_overflow,
    output logic                proto_err
);
    typedef struct packed {
        byte_t hold;
        logic  oe;
        logic  perr;
        logic  ovf;
    } top_state_t;

    top_state_t s_d, s_q;
    logic  rd_fall, wr_fall, rd_try, rd_take;
    logic  q_empty, q_full, q_dropped, has_credit;
    byte_t q_head;

    fbb_strobe_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .strobe_n(cpu_rd_n), .fall(rd_fall));
    fbb_strobe_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .strobe_n(cpu_wr_n), .fall(wr_fall));

    // write wins: a read edge during a low write strobe is discarded
    assign rd_try  = rd_fall && cpu_wr_n;
    assign rd_take = rd_try && !q_empty;

    fbb_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push(host_push), .push_data(host_push_data),
        .pop(rd_try), .head(q_head),
        .empty(q_empty), .full(q_full), .dropped(q_dropped)
    );

    fbb_tx_credit #(.CREDIT_W(CREDIT_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .grant(host_grant), .grant_count(host_grant_count),
        .wr_fire(wr_fall), .wdata(cpu_wdata),
        .has_credit(has_credit),
        .tx_valid(host_tx_valid), .tx_data(host_tx_data)
    );

    always_comb begin
        s_d = s_q;
        if (cpu_rd_n)     s_d.oe = 1'b0;
        else if (rd_take) s_d.oe = 1'b1;
        if (rd_take)      s_d.hold = q_head;
        s_d.perr = s_q.perr | (~cpu_rd_n & ~cpu_wr_n);
        s_d.ovf  = s_q.ovf | q_dropped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_rdata_oe  = s_q.oe & ~cpu_rd_n;
    assign cpu_rdata     = cpu_rdata_oe ? s_q.hold : '0;
    assign cpu_rxf_n     = q_empty;
    assign cpu_txe_n     = ~has_credit;
    assign host_overflow = s_q.ovf;
    assign proto_err     = s_q.perr;

    // R10: the protocol error flag never clears before reset
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    // R11: the overflow flag never clears before reset
    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_overflow |=> host_overflow);
    // R10: a read edge blocked by a low write strobe cannot enable the bus
    assert_read_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall && !cpu_wr_n && !s_q.oe) |=> !cpu_rdata_oe);
endmodule

// File: tb/tb_fifo_byte_bridge.sv
`timescale 1ns/1ps
module tb_fifo_byte_bridge;
    localparam int CW = 8;
    localparam logic [1:0] OP_G = 2'd0, OP_P = 2'd1, OP_W = 2'd2, OP_R = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] arg;
        logic       ev;
        logic [7:0] ed;
    } vec_t;

    localparam vec_t VEC [0:10] = '{
        '{OP_G, 8'd2,   1'b0, 8'h00},
        '{OP_P, 8'hA1,  1'b0, 8'h00},
        '{OP_P, 8'hB2,  1'b0, 8'h00},
        '{OP_P, 8'hC3,  1'b0, 8'h00},
        '{OP_R, 8'h00,  1'b1, 8'hA1},
        '{OP_W, 8'h55,  1'b1, 8'h55},
        '{OP_R, 8'h00,  1'b1, 8'hB2},
        '{OP_W, 8'h66,  1'b1, 8'h66},
        '{OP_W, 8'h77,  1'b0, 8'h00},
        '{OP_R, 8'h00,  1'b1, 8'hC3},
        '{OP_R, 8'h00,  1'b0, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_rdata_oe, cpu_rxf_n, cpu_txe_n;
    logic host_push = 1'b0, host_grant = 1'b0;
    logic [7:0] host_push_data = '0;
    logic [CW-1:0] host_grant_count = '0;
    logic host_tx_valid, host_overflow, proto_err;
    logic [7:0] host_tx_data;

    int checks = 0, fails = 0;
    logic v;
    logic [7:0] d;

    always #2.5 clk = ~clk;

    fifo_byte_bridge #(.RX_DEPTH(16), .CREDIT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
        .cpu_rxf_n(cpu_rxf_n), .cpu_txe_n(cpu_txe_n),
        .host_push(host_push), .host_push_data(host_push_data),
        .host_grant(host_grant), .host_grant_count(host_grant_count),
        .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data),
        .host_overflow(host_overflow), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [7:0] b);
        host_push = 1'b1; host_push_data = b;
        @(negedge clk);
        host_push = 1'b0;
    endtask

    task automatic do_grant(input logic [CW-1:0] n);
        host_grant = 1'b1; host_grant_count = n;
        @(negedge clk);
        host_grant = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] b, output logic ov, output logic [7:0] od);
        cpu_wr_n = 1'b0; cpu_wdata = b;
        @(negedge clk);
        ov = host_tx_valid; od = host_tx_data;
        cpu_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(output logic ov, output logic [7:0] od);
        cpu_rd_n = 1'b0;
        @(negedge clk);
        ov = cpu_rdata_oe; od = cpu_rdata;
        cpu_rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rxf_n", cpu_rxf_n, 1);
        chk("R1 txe_n", cpu_txe_n, 1);
        chk("R1 oe", cpu_rdata_oe, 0);
        chk("R1 rdata", cpu_rdata, 0);
        chk("R1 tx_valid", host_tx_valid, 0);
        chk("R1 flags", {proto_err, host_overflow}, 0);

        // table walk: R3 order, R7 pulse, R8 no credit, R4 empty read
        for (int i = 0; i < 11; i++) begin
            case (VEC[i].op)
                OP_G: do_grant(VEC[i].arg);
                OP_P: do_push(VEC[i].arg);
                OP_W: begin
                    do_write(VEC[i].arg, v, d);
                    chk("R7/R8 tx_valid", v, VEC[i].ev);
                    if (VEC[i].ev) chk("R7 tx_data", d, VEC[i].ed);
                end
                default: begin
                    do_read(v, d);
                    chk("R3/R4 oe", v, VEC[i].ev);
                    chk("R3/R4 rdata", d, VEC[i].ed);
                end
            endcase
        end
        chk("R4 rxf_n high after drain", cpu_rxf_n, 1);
        chk("R7 txe_n high after credit used", cpu_txe_n, 1);
        chk("R5 oe low with rd_n high", cpu_rdata_oe, 0);
        chk("R5 rdata zero with rd_n high", cpu_rdata, 0);

        // R2 push shows up on rxf_n next cycle
        do_push(8'h71);
        chk("R2 rxf_n low after push", cpu_rxf_n, 0);
        do_push(8'h72);

        // R9 read strobe held low pops once
        cpu_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 held read data", cpu_rdata, 8'h71);
        cpu_rd_n = 1'b1;
        @(negedge clk);
        chk("R9 one byte remains", cpu_rxf_n, 0);
        do_read(v, d);
        chk("R9 second byte", d, 8'h72);
        chk("R4 rxf_n high", cpu_rxf_n, 1);

        // R9 write strobe held low pulses once
        do_grant(8'd3);
        chk("R6 txe_n low after grant", cpu_txe_n, 0);
        cpu_wr_n = 1'b0; cpu_wdata = 8'h33;
        @(negedge clk);
        chk("R9 first cycle valid", host_tx_valid, 1);
        @(negedge clk);
        chk("R9 second cycle no valid", host_tx_valid, 0);
        @(negedge clk);
        chk("R9 third cycle no valid", host_tx_valid, 0);
        cpu_wr_n = 1'b1;
        @(negedge clk);

        // R6 grant replaces credit
        do_grant(8'd5);
        do_grant(8'd1);
        do_write(8'h44, v, d);
        chk("R6 write accepted", v, 1);
        chk("R6 credit replaced not added", cpu_txe_n, 1);

        // R10 collision: write wins, read ignored, sticky flag
        do_push(8'h10);
        do_grant(8'd1);
        chk("R10 flag clear before", proto_err, 0);
        cpu_rd_n = 1'b0; cpu_wr_n = 1'b0; cpu_wdata = 8'h99;
        @(negedge clk);
        chk("R10 write accepted", host_tx_valid, 1);
        chk("R10 write data", host_tx_data, 8'h99);
        chk("R10 read ignored", cpu_rdata_oe, 0);
        chk("R10 flag set", proto_err, 1);
        cpu_rd_n = 1'b1; cpu_wr_n = 1'b1;
        @(negedge clk);
        chk("R10 queue kept byte", cpu_rxf_n, 0);
        do_read(v, d);
        chk("R10 byte intact", d, 8'h10);
        chk("R10 flag sticky", proto_err, 1);

        // R11 overflow
        for (int i = 0; i < 16; i++) do_push(8'h20 + 8'(i));
        chk("R11 no overflow at depth", host_overflow, 0);
        do_push(8'hEE);
        chk("R11 overflow flagged", host_overflow, 1);
        for (int i = 0; i < 16; i++) begin
            do_read(v, d);
            chk("R11 order kept", d, 8'h20 + 8'(i));
        end
        chk("R11 dropped byte absent", cpu_rxf_n, 1);
        chk("R11 flag sticky", host_overflow, 1);

        // R12 grant and write in same cycle
        host_grant = 1'b1; host_grant_count = 8'd2;
        cpu_wr_n = 1'b0; cpu_wdata = 8'h42;
        @(negedge clk);
        host_grant = 1'b0;
        chk("R12 write on new grant", host_tx_valid, 1);
        chk("R12 data", host_tx_data, 8'h42);
        cpu_wr_n = 1'b1;
        @(negedge clk);
        chk("R12 one credit left", cpu_txe_n, 0);
        do_write(8'h43, v, d);
        chk("R12 second write", v, 1);
        chk("R12 credit exhausted", cpu_txe_n, 1);

        finish_run();
    end
endmodule